// File: doc/BRIEF.md
# Timed Triple-Press Detector

This block watches one push-button line that is asynchronous to the system clock. It raises a hit indicator when a set number of button presses lands inside a fixed time window. The default is three presses. A press is a low-to-high change of the button.

The first press opens the window. No timer runs freely in the background. If the window runs out before the last press arrives, all progress is dropped and the block goes back to idle. The next press then starts a fresh attempt.

Once the count is met, the indicator stays on for a fixed hold interval. Any presses during the hold are discarded. Both the window and the hold are parameters given in clock cycles. The defaults suit a 5 s interval on a 50 MHz clock.

Inside the block, the button is resampled through a flip-flop chain. A single-cycle pulse then marks each rising edge. All counting uses one down-counter on the same clock. The button is assumed to be free of contact bounce.

The block has no data stream, so it has no valid/ready interface. Every pin is a plain level-sensitive control or status line.

Top module: `press_trio_detect`

## Requirements
- R1: While `rst` is high and on the first cycle after it is released, `triple_hit` and `window_open` are both 0.
- R2: After `button_raw` goes from low to high, `window_open` rises on clock edge k+SYNC_STAGES. Edge k is the first clock edge that samples the button high.
- R3: A button held high for many cycles counts as exactly one press. Only a new low-to-high change counts again.
- R4: When the PRESSES-th press (default 3) of an open window is taken in, `triple_hit` rises on the same edge, SYNC_STAGES+1 edges after that press first reaches the block.
- R5: With only one press, `window_open` stays high for exactly WINDOW_CYCLES cycles and then returns to 0.
- R6: A later press taken in j cycles after the first one joins the window if 1 <= j <= WINDOW_CYCLES-1. At j = WINDOW_CYCLES, the old window has expired and the press opens a new window with a count of one. In that case `window_open` stays high without a gap.
- R7: `triple_hit` stays high for exactly HOLD_CYCLES cycles and then clears.
- R8: Presses that arrive while `triple_hit` is high have no effect. They do not extend the hold, and they do not open a window after it.
- R9: `triple_hit` and `window_open` are never high together. The window closes on the edge where the detection fires.
- R10: A synchronous reset in the middle of a window clears the partial press count, so the next press starts a new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| button_raw | input | 1 | Asynchronous, debounced push-button level, high = pressed |
| triple_hit | output | 1 | High for HOLD_CYCLES cycles after a successful detection |
| window_open | output | 1 | High while a press window is open and counting |

## Verification
The hardest cases to reach from the ports are the two window edges. One is a press taken in on the last cycle of the window. The other is a press taken in on the very cycle the window expires.

Each of these differs from its neighbour by a single clock. The bench relies on a fixed fact: the press-to-press spacing at the detector equals the spacing of the button's rising edges as driven. It therefore drives rises at exact cycle offsets from the first press, with gaps of WINDOW_CYCLES-1 and WINDOW_CYCLES.

It then checks two things:
- the hit for the in-window press;
- for the expiring press, an unbroken open window twice the nominal length, which shows the window was restarted and not extended.

// File: rtl/press_trio_pkg.sv
package press_trio_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE    = 2'd0,
    MODE_ARMED   = 2'd1,
    MODE_LATCHED = 2'd2
  } press_mode_t;

endpackage

// File: rtl/press_sync_chain.sv
module press_sync_chain #(
  parameter int unsigned STAGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] stage_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= 1'b0;
        else     stage_q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= 1'b0;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/press_rise_detect.sv
module press_rise_detect (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic rise_o
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;

  // R3
  rise_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o)
    else $error("rise pulse longer than one cycle");

endmodule

// File: rtl/press_window_fsm.sv
module press_window_fsm
  import press_trio_pkg::*;
#(
  parameter int unsigned WINDOW_CYCLES = 250_000_000,
  parameter int unsigned HOLD_CYCLES   = 250_000_000,
  parameter int unsigned PRESSES       = 3,
  parameter int unsigned CW            = 28
) (
  input  logic clk,
  input  logic rst,
  input  logic rise_i,
  output logic hit_o,
  output logic open_o
);

  localparam int unsigned TW = (PRESSES > 2) ? $clog2(PRESSES) : 1;
  localparam logic [CW-1:0] WIN_LOAD  = CW'(WINDOW_CYCLES - 1);
  localparam logic [CW-1:0] HOLD_LOAD = CW'(HOLD_CYCLES - 1);
  localparam logic [TW-1:0] LAST_TALLY = TW'(PRESSES - 1);

  press_mode_t     mode_q, mode_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [TW-1:0]   tally_q, tally_d;
  logic            cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    mode_d  = mode_q;
    cnt_d   = cnt_q;
    tally_d = tally_q;
    unique case (mode_q)
      MODE_IDLE: begin
        if (rise_i) begin
          mode_d  = MODE_ARMED;
          tally_d = TW'(1);
          cnt_d   = WIN_LOAD;
        end
      end
      MODE_ARMED: begin
        if (cnt_zero) begin
          if (rise_i) begin
            tally_d = TW'(1);
            cnt_d   = WIN_LOAD;
          end else begin
            mode_d  = MODE_IDLE;
            tally_d = '0;
          end
        end else if (rise_i) begin
          if (tally_q == LAST_TALLY) begin
            mode_d  = MODE_LATCHED;
            tally_d = '0;
            cnt_d   = HOLD_LOAD;
          end else begin
            tally_d = tally_q + TW'(1);
            cnt_d   = cnt_q - CW'(1);
          end
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      MODE_LATCHED: begin
        if (cnt_zero) mode_d = MODE_IDLE;
        else          cnt_d  = cnt_q - CW'(1);
      end
      default: begin
        mode_d  = MODE_IDLE;
        cnt_d   = '0;
        tally_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_IDLE;
      cnt_q   <= '0;
      tally_q <= '0;
    end else begin
      mode_q  <= mode_d;
      cnt_q   <= cnt_d;
      tally_q <= tally_d;
    end
  end

  assign hit_o  = (mode_q == MODE_LATCHED);
  assign open_o = (mode_q == MODE_ARMED);

  // R4
  hit_needs_press_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hit_o) |-> $past(rise_i))
    else $error("hit rose without a press");

  // R7
  hit_hold_persist_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_o && !cnt_zero) |=> hit_o)
    else $error("hit dropped before hold count ran out");

  // R9
  hit_open_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(hit_o && open_o))
    else $error("hit and window open together");

  // R5
  window_expire_chk: assert property (@(posedge clk) disable iff (rst)
    (open_o && cnt_zero && !rise_i) |=> (!open_o && tally_q == '0))
    else $error("window did not close on expiry");

endmodule

// File: rtl/press_trio_detect.sv
module press_trio_detect #(
  parameter int unsigned WINDOW_CYCLES = 250_000_000,
  parameter int unsigned HOLD_CYCLES   = 250_000_000,
  parameter int unsigned PRESSES       = 3,
  parameter int unsigned SYNC_STAGES   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic button_raw,
  output logic triple_hit,
  output logic window_open
);

  localparam int unsigned SPAN = (WINDOW_CYCLES > HOLD_CYCLES) ? WINDOW_CYCLES : HOLD_CYCLES;
  localparam int unsigned CW   = (SPAN > 2) ? $clog2(SPAN) : 1;

  logic btn_sync;
  logic btn_rise;

  press_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (button_raw),
    .sync_o  (btn_sync)
  );

  press_rise_detect u_rise (
    .clk     (clk),
    .rst     (rst),
    .level_i (btn_sync),
    .rise_o  (btn_rise)
  );

  press_window_fsm #(
    .WINDOW_CYCLES (WINDOW_CYCLES),
    .HOLD_CYCLES   (HOLD_CYCLES),
    .PRESSES       (PRESSES),
    .CW            (CW)
  ) u_fsm (
    .clk    (clk),
    .rst    (rst),
    .rise_i (btn_rise),
    .hit_o  (triple_hit),
    .open_o (window_open)
  );

endmodule

// File: tb/press_trio_detect_test.sv
module press_trio_detect_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 40;
  localparam int H = 24;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic button_raw = 1'b0;
  logic triple_hit;
  logic window_open;

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 1'b0;

  int hit_run = 0, hit_last = 0, hit_rises = 0;
  int win_run = 0, win_last = 0, win_rises = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  press_trio_detect #(
    .WINDOW_CYCLES (W),
    .HOLD_CYCLES   (H),
    .PRESSES       (3),
    .SYNC_STAGES   (N)
  ) uut (
    .clk         (clk),
    .rst         (rst),
    .button_raw  (button_raw),
    .triple_hit  (triple_hit),
    .window_open (window_open)
  );

  always @(negedge clk) begin
    if (triple_hit) begin
      if (hit_run == 0) hit_rises++;
      hit_run++;
    end else if (hit_run != 0) begin
      hit_last = hit_run;
      hit_run = 0;
    end
    if (window_open) begin
      if (win_run == 0) win_rises++;
      win_run++;
    end else if (win_run != 0) begin
      win_last = win_run;
      win_run = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // rising edge now, next rising edge driven exactly gap cycles later
  task automatic tap_gap(input int gap);
    button_raw = 1'b1;
    @(negedge clk);
    button_raw = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  // one press, then wait until its effect is visible on the outputs
  task automatic press_and_wait();
    button_raw = 1'b1;
    @(negedge clk);
    button_raw = 1'b0;
    repeat (N) @(negedge clk);
  endtask

  task automatic settle();
    button_raw = 1'b0;
    repeat (3 * W) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(triple_hit == 1'b0, "R1 hit in reset", triple_hit, 0);
    chk(window_open == 1'b0, "R1 open in reset", window_open, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(triple_hit == 1'b0 && window_open == 1'b0, "R1 after release",
        {triple_hit, window_open}, 0);
  endtask

  task automatic t_latency_and_window();
    button_raw = 1'b1;
    @(negedge clk);
    button_raw = 1'b0;
    repeat (N - 1) @(negedge clk);
    chk(window_open == 1'b0, "R2 open too early", window_open, 0);
    @(negedge clk);
    chk(window_open == 1'b1, "R2 open latency", window_open, 1);
    settle();
    chk(win_last == W, "R5 single press window length", win_last, W);
    chk(hit_rises == 0, "R5 no hit from one press", hit_rises, 0);
  endtask

  task automatic t_triple();
    tap_gap(4);
    tap_gap(4);
    button_raw = 1'b1;
    @(negedge clk);
    button_raw = 1'b0;
    repeat (N - 1) @(negedge clk);
    chk(triple_hit == 1'b0, "R4 hit too early", triple_hit, 0);
    chk(window_open == 1'b1, "R4 window open before third", window_open, 1);
    @(negedge clk);
    chk(triple_hit == 1'b1, "R4 hit latency", triple_hit, 1);
    chk(window_open == 1'b0, "R9 window closes on hit", window_open, 0);
    settle();
    chk(hit_last == H, "R7 hold length", hit_last, H);
    chk(win_last == 8, "R9 window span before hit", win_last, 8);
  endtask

  task automatic t_expire();
    int rises0;
    rises0 = hit_rises;
    tap_gap(5);
    button_raw = 1'b1;
    @(negedge clk);
    button_raw = 1'b0;
    settle();
    chk(window_open == 1'b0, "R5 window expired", window_open, 0);
    press_and_wait();
    chk(window_open == 1'b1, "R5 late press opens new window", window_open, 1);
    chk(hit_rises == rises0, "R5 no hit after expiry", hit_rises, rises0);
    settle();
  endtask

  task automatic t_boundary_in();
    tap_gap(2);
    tap_gap(W - 3);
    press_and_wait();
    chk(triple_hit == 1'b1, "R6 press at W-1 counts", triple_hit, 1);
    settle();
  endtask

  task automatic t_boundary_out();
    int rises0;
    rises0 = hit_rises;
    tap_gap(2);
    tap_gap(W - 2);
    press_and_wait();
    chk(triple_hit == 1'b0, "R6 press at W does not hit", triple_hit, 0);
    chk(window_open == 1'b1, "R6 press at W reopens", window_open, 1);
    settle();
    chk(win_last == 2 * W, "R6 restarted window unbroken", win_last, 2 * W);
    chk(hit_rises == rises0, "R6 no hit in restart", hit_rises, rises0);
  endtask

  task automatic t_held();
    button_raw = 1'b1;
    repeat (12) @(negedge clk);
    button_raw = 1'b0;
    @(negedge clk);
    press_and_wait();
    chk(triple_hit == 1'b0, "R3 held level counts once", triple_hit, 0);
    chk(window_open == 1'b1, "R3 window still open", window_open, 1);
    press_and_wait();
    chk(triple_hit == 1'b1, "R3 third distinct press hits", triple_hit, 1);
    settle();
  endtask

  task automatic t_ignore();
    int wr0;
    tap_gap(3);
    tap_gap(3);
    press_and_wait();
    chk(triple_hit == 1'b1, "R8 hit before ignored taps", triple_hit, 1);
    wr0 = win_rises;
    tap_gap(3);
    tap_gap(3);
    tap_gap(3);
    settle();
    chk(hit_last == H, "R8 hold not extended", hit_last, H);
    chk(win_rises == wr0, "R8 no window from ignored taps", win_rises, wr0);
    chk(window_open == 1'b0, "R8 idle after hold", window_open, 0);
  endtask

  task automatic t_reset_mid();
    tap_gap(3);
    tap_gap(3);
    repeat (N + 1) @(negedge clk);
    chk(window_open == 1'b1, "R10 window open before reset", window_open, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(window_open == 1'b0, "R10 reset closes window", window_open, 0);
    press_and_wait();
    chk(triple_hit == 1'b0, "R10 count cleared by reset", triple_hit, 0);
    chk(window_open == 1'b1, "R10 fresh window", window_open, 1);
    settle();
  endtask

  initial begin
    repeat (100_000) @(posedge clk);
    if (!done) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    repeat (2) @(negedge clk);
    t_latency_and_window();
    t_triple();
    t_expire();
    t_boundary_in();
    t_boundary_out();
    t_held();
    t_ignore();
    t_reset_mid();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule